// File: doc/BRIEF.md
# Pin-Ownership-Filtered GPIO Configuration Registers

This block is the configuration register bank of one 16-pin general-purpose I/O port. A simple memory-mapped bus reaches it, and every bus access carries an attribute that says whether the master is secure. The bank holds six registers:

- a pin-mode register
- an output-level register
- a read-only input-level register
- two alternate-function select registers
- a per-pin ownership register

The stored fields drive the pad and gating logic directly, through the `pin_*` outputs.

Each pin carries one ownership bit. When the bit is set, the pin belongs to the secure side, and a non-secure master sees that pin's mode, level and function fields as zero and cannot change them. Pins whose bit is clear are open to both kinds of master. Only a secure master can change the ownership register. Any master can read it, so software can find out which pins it may use. A global protection-enable input switches the filtering on. While that input is low, every access is treated as secure.

Read data comes back one clock after the read strobe. It is carried by a two-state response machine:

- `BUS_IDLE`: no response pending. The machine moves to `BUS_RESP` when a read strobe is seen (transition *read-issue*).
- `BUS_RESP`: the response is valid. The machine stays in `BUS_RESP` on another strobe (transition *read-chain*) and returns to `BUS_IDLE` when no strobe is present (transition *read-done*).

The input levels pass through a two-flop synchronizer and are then captured in the input-level register.

Top module: `gsr_port_regbank`

## Requirements
- R1: After reset, every ownership bit is 1. Every mode, output-level and alternate-function field is 0, and no read response is pending.
- R2: A read strobe sampled at a clock edge yields `bus_rvalid`=1 and the read data during the following cycle only, unless another strobe follows.
- R3: A secure access can write and read every field of every pin. The fields are placed as follows:
  - Mode, at byte offset 0x00: pin p occupies bits [2p+1:2p].
  - Output level, at 0x04: pin p occupies bit p.
  - Input level, at 0x08: pin p occupies bit p.
  - Ownership, at 0x14: pin p occupies bit p.
- R4: With protection enabled, a non-secure access to a pin whose ownership bit is 1 returns 0 in that pin's mode, output, input and function fields. Its writes to those fields leave them unchanged.
- R5: A non-secure access to a pin whose ownership bit is 0 reads and writes that pin's fields exactly as a secure access would.
- R6: Only a secure access can change the ownership register, and any access can read it in full.
- R7: While `tz_enable` is 0, non-secure accesses behave as secure ones for every register, including the ownership register.
- R8: A change on `pin_in` is not visible to an input-level read whose strobe is sampled at the second clock edge after the change. It is visible to a read whose strobe is sampled at the fourth edge.
- R9: Writes to the input-level register, to unmapped offsets and to offsets that are not word-aligned change no state. Reads of unmapped or unaligned offsets return 0.
- R10: `pin_mode`, `pin_out`, `pin_afsel` and `pin_secure` show the new register contents from the clock edge that performs the write.
- R11: Alternate-function fields are 4 bits per pin. Pins 0 to 7 sit in the register at 0x0C, and pins 8 to 15 in the register at 0x10, with pin p at bits [4(p mod 8)+3 : 4(p mod 8)]. On `pin_afsel`, pin p occupies bits [4p+3:4p].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tz_enable | input | 1 | Global protection enable; 0 treats every access as secure |
| bus_addr | input | 8 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_secure | input | 1 | 1 when the current access comes from a secure master |
| bus_rdata | output | 32 | Read data, valid while bus_rvalid is 1 |
| bus_rvalid | output | 1 | Read response valid, one cycle after the strobe |
| pin_in | input | 16 | Asynchronous pad input levels |
| pin_mode | output | 32 | Mode field of each pin, 2 bits per pin |
| pin_out | output | 16 | Output level of each pin |
| pin_afsel | output | 64 | Alternate-function select of each pin, 4 bits per pin |
| pin_secure | output | 16 | Ownership bit of each pin |

## Verification
A corrupted ownership bit shows up on `pin_secure` at the next negative clock edge. From then on, a non-secure read of the mode, output or function register returns a nonzero field where the bench expects zero, or the reverse. A non-secure write also lands on, or misses, the matching slice of `pin_mode`, `pin_out` or `pin_afsel` in the same cycle. A wrong response-machine state appears at once as a `bus_rvalid` pulse without a matching expected entry, or as a missing pulse. An input path that is too short or too long appears in the two reads placed on either side of the synchronizer latency.

// File: rtl/gsr_pkg.sv
package gsr_pkg;

    // Byte offsets of the register windows
    localparam int OFS_MODE    = 'h00;
    localparam int OFS_ODR     = 'h04;
    localparam int OFS_IDR     = 'h08;
    localparam int OFS_AF_BASE = 'h0C;
    localparam int OFS_SEC     = 'h14;

    // Decoded target of a bus access
    typedef enum logic [2:0] {
        KIND_NONE,
        KIND_MODE,
        KIND_ODR,
        KIND_IDR,
        KIND_AF,
        KIND_SEC
    } reg_kind_e;

    // Read response machine
    typedef enum logic {
        BUS_IDLE,
        BUS_RESP
    } bus_state_e;

endpackage

// File: rtl/gsr_sync.sv
module gsr_sync #(
    parameter int WIDTH  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= '0;
            end
        end else begin
            stage_q[0] <= async_in;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gsr_access_filter.sv
module gsr_access_filter #(
    parameter int NUM_PINS = 16
) (
    input  logic                tz_enable,
    input  logic                bus_secure,
    input  logic [NUM_PINS-1:0] sec_attr,
    output logic                eff_secure,
    output logic [NUM_PINS-1:0] pin_allow
);

    // With protection off, every master counts as secure
    assign eff_secure = bus_secure | ~tz_enable;

    // A pin's fields are reachable by a secure master, or by anyone if the pin is open
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        assign pin_allow[p] = eff_secure | ~sec_attr[p];
    end

endmodule

// File: rtl/gsr_regs.sv
module gsr_regs
    import gsr_pkg::*;
#(
    parameter int NUM_PINS = 16,
    parameter int MODE_W   = 2,
    parameter int AF_W     = 4,
    parameter int DATA_W   = 32,
    parameter int AF_IDX_W = 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  reg_kind_e                  kind,
    input  logic [AF_IDX_W-1:0]        af_idx,
    input  logic [DATA_W-1:0]          wdata,
    input  logic                       eff_secure,
    input  logic [NUM_PINS-1:0]        pin_allow,
    input  logic [NUM_PINS-1:0]        pin_sync,
    output logic [NUM_PINS*MODE_W-1:0] mode_q,
    output logic [NUM_PINS-1:0]        odr_q,
    output logic [NUM_PINS-1:0]        idr_q,
    output logic [NUM_PINS*AF_W-1:0]   af_q,
    output logic [NUM_PINS-1:0]        sec_q
);

    localparam int PINS_PER_AFR = DATA_W / AF_W;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            odr_q  <= '0;
            idr_q  <= '0;
            af_q   <= '0;
            sec_q  <= '1;
        end else begin
            idr_q <= pin_sync;
            if (wr_en) begin
                for (int p = 0; p < NUM_PINS; p++) begin
                    if (pin_allow[p]) begin
                        unique case (kind)
                            KIND_MODE: mode_q[p*MODE_W +: MODE_W] <= wdata[p*MODE_W +: MODE_W];
                            KIND_ODR:  odr_q[p] <= wdata[p];
                            KIND_AF: begin
                                if (af_idx == AF_IDX_W'(p / PINS_PER_AFR)) begin
                                    af_q[p*AF_W +: AF_W] <= wdata[(p % PINS_PER_AFR)*AF_W +: AF_W];
                                end
                            end
                            default: ;
                        endcase
                    end
                end
                if (kind == KIND_SEC && eff_secure) begin
                    sec_q <= wdata[NUM_PINS-1:0];
                end
            end
        end
    end

    // R6
    sec_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && kind == KIND_SEC && eff_secure) |=> $stable(sec_q));

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_guard
        // R4
        locked_pin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !pin_allow[p]) |=>
                ($stable(mode_q[p*MODE_W +: MODE_W]) && $stable(odr_q[p]) &&
                 $stable(af_q[p*AF_W +: AF_W])));
    end

endmodule

// File: rtl/gsr_bus_fsm.sv
module gsr_bus_fsm
    import gsr_pkg::*;
#(
    parameter int NUM_PINS = 16,
    parameter int MODE_W   = 2,
    parameter int AF_W     = 4,
    parameter int DATA_W   = 32,
    parameter int AF_IDX_W = 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_re,
    input  reg_kind_e                  kind,
    input  logic [AF_IDX_W-1:0]        af_idx,
    input  logic [NUM_PINS-1:0]        pin_allow,
    input  logic [NUM_PINS*MODE_W-1:0] mode_q,
    input  logic [NUM_PINS-1:0]        odr_q,
    input  logic [NUM_PINS-1:0]        idr_q,
    input  logic [NUM_PINS*AF_W-1:0]   af_q,
    input  logic [NUM_PINS-1:0]        sec_q,
    output logic [DATA_W-1:0]          bus_rdata,
    output logic                       bus_rvalid
);

    localparam int PINS_PER_AFR = DATA_W / AF_W;

    bus_state_e        state_q, state_d;
    logic [DATA_W-1:0] rd_next;
    logic [DATA_W-1:0] rdata_q;

    // Filtered read mux
    always_comb begin
        rd_next = '0;
        unique case (kind)
            KIND_MODE: begin
                for (int p = 0; p < NUM_PINS; p++) begin
                    rd_next[p*MODE_W +: MODE_W] = pin_allow[p] ? mode_q[p*MODE_W +: MODE_W] : '0;
                end
            end
            KIND_ODR: rd_next[NUM_PINS-1:0] = odr_q & pin_allow;
            KIND_IDR: rd_next[NUM_PINS-1:0] = idr_q & pin_allow;
            KIND_AF: begin
                for (int p = 0; p < NUM_PINS; p++) begin
                    if (af_idx == AF_IDX_W'(p / PINS_PER_AFR)) begin
                        rd_next[(p % PINS_PER_AFR)*AF_W +: AF_W] =
                            pin_allow[p] ? af_q[p*AF_W +: AF_W] : '0;
                    end
                end
            end
            KIND_SEC: rd_next[NUM_PINS-1:0] = sec_q;
            default: rd_next = '0;
        endcase
    end

    // Next-state: read-issue, read-chain, read-done
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: if (bus_re)  state_d = BUS_RESP;
            BUS_RESP: if (!bus_re) state_d = BUS_IDLE;
            default:  state_d = BUS_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata_q <= '0;
        else if (bus_re) rdata_q <= rd_next;
    end

    assign bus_rdata  = rdata_q;
    assign bus_rvalid = (state_q == BUS_RESP);

    // R2
    resp_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_re |=> bus_rvalid);

    // R2
    no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |=> !bus_rvalid);

    // R4
    locked_level_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && kind == KIND_ODR) |=>
            ((bus_rdata[NUM_PINS-1:0] & ~$past(pin_allow)) == '0));

endmodule

// File: rtl/gsr_port_regbank.sv
module gsr_port_regbank
    import gsr_pkg::*;
#(
    parameter int NUM_PINS    = 16,
    parameter int MODE_W      = 2,
    parameter int AF_W        = 4,
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tz_enable,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [DATA_W-1:0]          bus_wdata,
    input  logic                       bus_we,
    input  logic                       bus_re,
    input  logic                       bus_secure,
    output logic [DATA_W-1:0]          bus_rdata,
    output logic                       bus_rvalid,
    input  logic [NUM_PINS-1:0]        pin_in,
    output logic [NUM_PINS*MODE_W-1:0] pin_mode,
    output logic [NUM_PINS-1:0]        pin_out,
    output logic [NUM_PINS*AF_W-1:0]   pin_afsel,
    output logic [NUM_PINS-1:0]        pin_secure
);

    localparam int PINS_PER_AFR = DATA_W / AF_W;
    localparam int AF_REGS      = (NUM_PINS + PINS_PER_AFR - 1) / PINS_PER_AFR;
    localparam int AF_IDX_W     = (AF_REGS > 1) ? $clog2(AF_REGS) : 1;
    localparam int WORD_W       = ADDR_W - 2;

    reg_kind_e            kind;
    logic [AF_IDX_W-1:0]  af_idx;
    logic [WORD_W-1:0]    word;
    logic                 eff_secure;
    logic [NUM_PINS-1:0]  pin_allow;
    logic [NUM_PINS-1:0]  pin_sync;
    logic [NUM_PINS-1:0]  idr_q;
    logic [NUM_PINS-1:0]  sec_q;

    // Address decode: only word-aligned offsets hit a register
    assign word = bus_addr[ADDR_W-1:2];

    always_comb begin
        kind   = KIND_NONE;
        af_idx = '0;
        if (bus_addr[1:0] == 2'b00) begin
            if (word == WORD_W'(OFS_MODE / 4)) begin
                kind = KIND_MODE;
            end else if (word == WORD_W'(OFS_ODR / 4)) begin
                kind = KIND_ODR;
            end else if (word == WORD_W'(OFS_IDR / 4)) begin
                kind = KIND_IDR;
            end else if (word == WORD_W'(OFS_SEC / 4)) begin
                kind = KIND_SEC;
            end else if (word >= WORD_W'(OFS_AF_BASE / 4) &&
                         word <  WORD_W'(OFS_AF_BASE / 4 + AF_REGS)) begin
                kind   = KIND_AF;
                af_idx = AF_IDX_W'(word - WORD_W'(OFS_AF_BASE / 4));
            end
        end
    end

    gsr_sync #(
        .WIDTH  (NUM_PINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    gsr_access_filter #(
        .NUM_PINS (NUM_PINS)
    ) u_filter (
        .tz_enable  (tz_enable),
        .bus_secure (bus_secure),
        .sec_attr   (sec_q),
        .eff_secure (eff_secure),
        .pin_allow  (pin_allow)
    );

    gsr_regs #(
        .NUM_PINS (NUM_PINS),
        .MODE_W   (MODE_W),
        .AF_W     (AF_W),
        .DATA_W   (DATA_W),
        .AF_IDX_W (AF_IDX_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (bus_we),
        .kind       (kind),
        .af_idx     (af_idx),
        .wdata      (bus_wdata),
        .eff_secure (eff_secure),
        .pin_allow  (pin_allow),
        .pin_sync   (pin_sync),
        .mode_q     (pin_mode),
        .odr_q      (pin_out),
        .idr_q      (idr_q),
        .af_q       (pin_afsel),
        .sec_q      (sec_q)
    );

    gsr_bus_fsm #(
        .NUM_PINS (NUM_PINS),
        .MODE_W   (MODE_W),
        .AF_W     (AF_W),
        .DATA_W   (DATA_W),
        .AF_IDX_W (AF_IDX_W)
    ) u_bus (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_re     (bus_re),
        .kind       (kind),
        .af_idx     (af_idx),
        .pin_allow  (pin_allow),
        .mode_q     (pin_mode),
        .odr_q      (pin_out),
        .idr_q      (idr_q),
        .af_q       (pin_afsel),
        .sec_q      (sec_q),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid)
    );

    assign pin_secure = sec_q;

    // Cycles since reset, saturating; supports the checks below
    logic [1:0] cyc_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cyc_q <= '0;
        else if (cyc_q != 2'd3)  cyc_q <= cyc_q + 2'd1;
    end

    // R1
    reset_values_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q == 2'd0) |-> (pin_secure == '1 && pin_mode == '0 && pin_out == '0 &&
                             pin_afsel == '0 && !bus_rvalid));

    // R8
    input_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q == 2'd3) |-> (idr_q == $past(pin_in, 3)));

    // R7
    open_mode_sec_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tz_enable && bus_we && kind == KIND_SEC) |=>
            (pin_secure == $past(bus_wdata[NUM_PINS-1:0])));

endmodule

// File: tb/gsr_port_regbank_test.sv
module gsr_port_regbank_test;

    localparam int CLK_PERIOD = 10;

    localparam logic [7:0] A_MODE = 8'h00;
    localparam logic [7:0] A_ODR  = 8'h04;
    localparam logic [7:0] A_IDR  = 8'h08;
    localparam logic [7:0] A_AFL  = 8'h0C;
    localparam logic [7:0] A_AFH  = 8'h10;
    localparam logic [7:0] A_SEC  = 8'h14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tz_enable = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic        bus_secure = 1'b0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic [15:0] pin_in = '0;
    logic [31:0] pin_mode;
    logic [15:0] pin_out;
    logic [63:0] pin_afsel;
    logic [15:0] pin_secure;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    gsr_port_regbank uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tz_enable  (tz_enable),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_we     (bus_we),
        .bus_re     (bus_re),
        .bus_secure (bus_secure),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .pin_in     (pin_in),
        .pin_mode   (pin_mode),
        .pin_out    (pin_out),
        .pin_afsel  (pin_afsel),
        .pin_secure (pin_secure)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d, input logic sec);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_secure = sec; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    // Driver: push the expected response, then issue the strobe
    task automatic bus_read(input logic [7:0] a, input logic sec,
                            input logic [31:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_addr = a; bus_secure = sec; bus_re = 1'b1;
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    // Monitor: pop and compare each response
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                n_chk++;
                n_fail++;
                $display("FAIL R2 unexpected response act=%h exp=none", bus_rdata);
            end else begin
                logic [31:0] e;
                string       t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, {32'h0, bus_rdata}, {32'h0, e});
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R2 watchdog act=hung exp=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 pin_secure", {48'h0, pin_secure}, 64'h0000_0000_0000_FFFF);
        check("R1 pin_mode",   {32'h0, pin_mode},   64'h0);
        check("R1 pin_out",    {48'h0, pin_out},    64'h0);
        check("R1 pin_afsel",  pin_afsel,           64'h0);
        check("R1 rvalid",     {63'h0, bus_rvalid}, 64'h0);
        bus_read(A_SEC, 1'b1, 32'h0000_FFFF, "R1 ownership read");
        bus_read(A_SEC, 1'b0, 32'h0000_FFFF, "R6 non-secure ownership read");

        // R4 all pins owned: non-secure write ignored, reads zero
        bus_write(A_MODE, 32'hFFFF_FFFF, 1'b0);
        check("R4 mode write blocked", {32'h0, pin_mode}, 64'h0);
        bus_read(A_MODE, 1'b0, 32'h0, "R4 mode read zero");

        // R3 / R10 secure write and read
        bus_write(A_MODE, 32'hA5A5_5A5A, 1'b1);
        check("R10 pin_mode follows write", {32'h0, pin_mode}, 64'hA5A5_5A5A);
        bus_read(A_MODE, 1'b1, 32'hA5A5_5A5A, "R3 secure mode read");

        // R6 ownership writes
        bus_write(A_SEC, 32'h0000_0000, 1'b0);
        check("R6 non-secure ownership write", {48'h0, pin_secure}, 64'hFFFF);
        bus_write(A_SEC, 32'h0000_00FF, 1'b1);
        check("R6 secure ownership write", {48'h0, pin_secure}, 64'h00FF);
        bus_read(A_SEC, 1'b0, 32'h0000_00FF, "R6 ownership readable");

        // R5 pins 8-15 open, R4 pins 0-7 owned
        bus_read(A_MODE, 1'b0, 32'hA5A5_0000, "R5 mode partial read");
        bus_write(A_MODE, 32'h1234_5678, 1'b0);
        check("R5 mode partial write", {32'h0, pin_mode}, 64'h1234_5A5A);

        bus_write(A_ODR, 32'h0000_FFFF, 1'b1);
        bus_write(A_ODR, 32'h0000_0000, 1'b0);
        check("R4 output partial write", {48'h0, pin_out}, 64'h00FF);
        bus_read(A_ODR, 1'b0, 32'h0, "R4 output read masked");
        bus_read(A_ODR, 1'b1, 32'h0000_00FF, "R3 output secure read");

        // R11 function select placement
        bus_write(A_AFL, 32'h89AB_CDEF, 1'b1);
        bus_write(A_AFH, 32'h7654_3210, 1'b1);
        check("R11 afsel secure", pin_afsel, 64'h7654_3210_89AB_CDEF);
        bus_write(A_AFL, 32'h0000_0000, 1'b0);
        bus_write(A_AFH, 32'hFFFF_FFFF, 1'b0);
        check("R11 afsel filtered", pin_afsel, 64'hFFFF_FFFF_89AB_CDEF);
        bus_read(A_AFL, 1'b0, 32'h0, "R4 afsel low read zero");
        bus_read(A_AFH, 1'b0, 32'hFFFF_FFFF, "R11 afsel high read");
        bus_read(A_AFL, 1'b1, 32'h89AB_CDEF, "R11 afsel low secure read");

        // R8 input path
        @(negedge clk);
        pin_in = 16'hBEEF;
        repeat (5) @(negedge clk);
        bus_read(A_IDR, 1'b1, 32'h0000_BEEF, "R8 input settled");
        bus_read(A_IDR, 1'b0, 32'h0000_BE00, "R4 input read masked");
        pin_in = 16'h1234;
        bus_read(A_IDR, 1'b1, 32'h0000_BEEF, "R8 input not yet visible");
        bus_read(A_IDR, 1'b1, 32'h0000_1234, "R8 input visible");

        // R9 ignored writes and unmapped reads
        bus_write(A_IDR, 32'h0000_FFFF, 1'b1);
        bus_read(A_IDR, 1'b1, 32'h0000_1234, "R9 input write ignored");
        bus_write(8'h18, 32'hFFFF_FFFF, 1'b1);
        bus_write(8'h02, 32'hFFFF_FFFF, 1'b1);
        bus_write(8'h15, 32'hFFFF_FFFF, 1'b1);
        check("R9 mode unchanged",   {32'h0, pin_mode},   64'h1234_5A5A);
        check("R9 output unchanged", {48'h0, pin_out},    64'h00FF);
        check("R9 owner unchanged",  {48'h0, pin_secure}, 64'h00FF);
        bus_read(8'h18, 1'b1, 32'h0, "R9 unmapped read");
        bus_read(8'h01, 1'b1, 32'h0, "R9 unaligned read");

        // R2 single-cycle response
        exp_q.push_back(32'h0000_00FF);
        tag_q.push_back("R2 response data");
        @(negedge clk);
        bus_addr = A_SEC; bus_secure = 1'b1; bus_re = 1'b1;
        @(negedge clk);
        bus_re = 1'b0;
        check("R2 rvalid next cycle", {63'h0, bus_rvalid}, 64'h1);
        @(negedge clk);
        check("R2 rvalid single cycle", {63'h0, bus_rvalid}, 64'h0);

        // R7 protection disabled
        @(negedge clk);
        tz_enable = 1'b0;
        bus_read(A_MODE, 1'b0, 32'h1234_5A5A, "R7 full mode read");
        bus_write(A_ODR, 32'h0000_AAAA, 1'b0);
        check("R7 output write", {48'h0, pin_out}, 64'hAAAA);
        bus_write(A_SEC, 32'h0000_0F00, 1'b0);
        check("R7 ownership write", {48'h0, pin_secure}, 64'h0F00);
        @(negedge clk);
        tz_enable = 1'b1;
        bus_read(A_ODR, 1'b0, 32'h0000_A0AA, "R5 output read new ownership");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_chk++;
            n_fail++;
            $display("FAIL R2 missing responses act=%0d exp=0", exp_q.size());
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule